// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits next to a DRAM access controller and owns the RAS and CAS strobes whenever the memory needs housekeeping. Out of reset it holds every strobe inactive for a fixed start-up pause. It then runs a chain of warm-up cycles, all of them CAS-before-RAS refreshes, and raises `init_done` once the last of them has finished precharging. The access controller must leave the memory alone until that flag is high.

After start-up, a free-running interval timer adds one refresh to a small saturating pending counter each time the per-row refresh budget expires. While refreshes are pending, the sequencer raises `ref_req`. When the controller answers with `ref_gnt`, the sequencer takes the strobes and drains every pending refresh back to back. CAS stays low across the whole burst while RAS is cycled. It drops `ref_req` after the last precharge. The device counts refresh rows itself, so no address is produced. Write-enable and output-enable are held inactive throughout.

States: PAUSE (start-up wait), LEAD (CAS low ahead of RAS), STROBE (RAS and CAS low), PRECH (RAS high, CAS low only when another refresh is chained), IDLE (waiting for a pending refresh and a grant). The transitions are:
- PAUSE→LEAD when the pause expires.
- IDLE→LEAD on a grant while refreshes are pending.
- LEAD→STROBE when the lead time expires.
- STROBE→PRECH when the RAS-low time expires.
- PRECH→STROBE when a refresh is chained.
- PRECH→LEAD when a refresh arrived after the chain decision.
- PRECH→IDLE when nothing is left. On the first such exit, `init_done` is set.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, `ras_n`, `cas_n`, `we_n` and `oe_n` are high and `ref_req` and `init_done` are low.
- R2: After reset is released, `cas_n` first goes low exactly PAUSE_CYC clock cycles later (50000 at the default 250 MHz and 200 µs). No RAS falling edge occurs before that.
- R3: After the pause, exactly INIT_CYCLES (8) refreshes are issued with a single CAS falling edge for the whole chain. `ref_req` stays low throughout. `init_done` rises when the last precharge ends, with both strobes high, and never falls again.
- R4: Every RAS falling edge is preceded by at least CSR_CYC (2) consecutive cycles of `cas_n` low. `cas_n` stays low for every cycle that `ras_n` is low.
- R5: Each RAS low pulse lasts exactly RAS_CYC (15) cycles. `ras_n` stays high for at least PRE_CYC (13) cycles between pulses, which gives a 28-cycle (112 ns) refresh period.
- R6: After `init_done`, one refresh becomes pending every INTERVAL_CYC (3906) cycles. The first one raises `ref_req` exactly 3906 cycles after `init_done` rises.
- R7: After start-up, no strobe moves unless a grant has been taken. `cas_n` falls in the cycle after `ref_gnt` is sampled high while `ref_req` is high.
- R8: The pending count saturates at MAX_PEND (4). One grant issues exactly min(pending, 4) refreshes with one CAS falling edge. `ref_req` falls and `cas_n` is high when the burst ends.
- R9: `we_n` and `oe_n` are high at every RAS falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Access controller hands over the strobes |
| ref_req | output | 1 | Refresh pending or in progress; the sequencer owns the strobes after a grant |
| init_done | output | 1 | Start-up sequence complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |

## Verification
The start-up path is exercised once with directed timing. That run separates an exact pause length from an off-by-one, and a chained warm-up from one that releases CAS between cycles. Refresh bursts are then driven with the grant held back for a random number of intervals (one to six) at a random offset inside the interval. A backlog of one tells apart single-refresh handling. A backlog above four exposes a missing or misplaced saturation. A short grant delay shows whether the strobes react before or after the grant. Per-pulse monitoring of RAS and CAS runs checks the lead, hold and precharge timing on every refresh in every burst.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_LEAD,
        ST_STROBE,
        ST_PRECH
    } rf_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_mhz);
        int c;
        c = (ns * clk_mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int INTERVAL_CYC = 3906
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int IW = $clog2(INTERVAL_CYC + 1);
    localparam logic [IW-1:0] LAST = IW'(INTERVAL_CYC - 1);

    logic [IW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
    parameter int MAX_PEND = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic pend_nz
);
    localparam int PW = $clog2(MAX_PEND + 1);
    localparam logic [PW-1:0] TOP = PW'(MAX_PEND);

    logic [PW-1:0] cnt_q;

    assign pend_nz = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R8
    pend_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP && inc && !dec) |=> (cnt_q == TOP));
    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));

endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
    import dram_refresh_pkg::*;
#(
    parameter int PAUSE_CYC   = 50000,
    parameter int CSR_CYC     = 2,
    parameter int RAS_CYC     = 15,
    parameter int PRE_CYC     = 13,
    parameter int INIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    input  logic pend_nz,
    output logic pend_dec,
    output logic ref_req,
    output logic init_done,
    output logic ras_n,
    output logic cas_n
);
    localparam int CW = $clog2(imax(PAUSE_CYC, imax(RAS_CYC, PRE_CYC)) + 1);
    localparam int NW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] L_PAUSE = CW'(PAUSE_CYC - 1);
    localparam logic [CW-1:0] L_CSR   = CW'(CSR_CYC - 1);
    localparam logic [CW-1:0] L_RAS   = CW'(RAS_CYC - 1);
    localparam logic [CW-1:0] L_PRE   = CW'(PRE_CYC - 1);

    rf_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [NW-1:0] left_q, left_d;
    logic          chain_q, chain_d;
    logic          done_q, done_d;

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        cnt_d    = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
        left_d   = left_q;
        chain_d  = chain_q;
        done_d   = done_q;
        pend_dec = 1'b0;
        unique case (state_q)
            ST_PAUSE: if (cnt_q == '0) begin
                state_d = ST_LEAD;
                cnt_d   = L_CSR;
                left_d  = NW'(INIT_CYCLES);
            end
            ST_IDLE: if (pend_nz && ref_gnt) begin
                state_d = ST_LEAD;
                cnt_d   = L_CSR;
            end
            ST_LEAD: if (cnt_q == '0) begin
                state_d = ST_STROBE;
                cnt_d   = L_RAS;
                if (done_q) pend_dec = 1'b1;
                else        left_d   = left_q - 1'b1;
            end
            ST_STROBE: if (cnt_q == '0) begin
                state_d = ST_PRECH;
                cnt_d   = L_PRE;
                chain_d = done_q ? pend_nz : (left_q != '0);
            end
            ST_PRECH: if (cnt_q == '0) begin
                if (chain_q) begin
                    state_d = ST_STROBE;
                    cnt_d   = L_RAS;
                    if (done_q) pend_dec = 1'b1;
                    else        left_d   = left_q - 1'b1;
                end else if (!done_q) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else if (pend_nz) begin
                    state_d = ST_LEAD;
                    cnt_d   = L_CSR;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PAUSE;
            cnt_q   <= L_PAUSE;
            left_q  <= '0;
            chain_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            left_q  <= left_d;
            chain_q <= chain_d;
            done_q  <= done_d;
        end
    end

    // Outputs
    always_comb begin
        ras_n     = (state_q != ST_STROBE);
        cas_n     = !((state_q == ST_LEAD) || (state_q == ST_STROBE) ||
                      (state_q == ST_PRECH && chain_q));
        ref_req   = done_q && ((state_q != ST_IDLE) || pend_nz);
        init_done = done_q;
    end

    // R4
    cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
    // R4
    cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);
    // R3
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    // R3
    no_req_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_req);
    // R7
    quiet_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !ref_req) |-> (ras_n && cas_n));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_refresh_pkg::*;
#(
    parameter int CLK_MHZ     = 250,
    parameter int PAUSE_US    = 200,
    parameter int REFRESH_MS  = 64,
    parameter int ROWS        = 4096,
    parameter int INIT_CYCLES = 8,
    parameter int MAX_PEND    = 4,
    parameter int T_CSR_NS    = 5,
    parameter int T_CHR_NS    = 10,
    parameter int T_RAS_NS    = 60,
    parameter int T_RP_NS     = 40,
    parameter int T_RC_NS     = 110
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic init_done,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic oe_n
);
    localparam int PAUSE_CYC    = PAUSE_US * CLK_MHZ;
    localparam int INTERVAL_CYC = (REFRESH_MS * 1000 * CLK_MHZ) / ROWS;
    localparam int CSR_CYC      = ns_to_cyc(T_CSR_NS, CLK_MHZ);
    localparam int RAS_CYC      = imax(ns_to_cyc(T_RAS_NS, CLK_MHZ),
                                       ns_to_cyc(T_CHR_NS, CLK_MHZ));
    localparam int PRE_CYC      = imax(ns_to_cyc(T_RP_NS, CLK_MHZ),
                                       ns_to_cyc(T_RC_NS, CLK_MHZ) - RAS_CYC);

    logic tick, pend_nz, pend_dec, done;

    rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk (clk), .rst_n (rst_n), .en (done), .tick (tick)
    );

    rfsh_pending_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk (clk), .rst_n (rst_n), .inc (tick), .dec (pend_dec), .pend_nz (pend_nz)
    );

    rfsh_seq_fsm #(
        .PAUSE_CYC   (PAUSE_CYC),
        .CSR_CYC     (CSR_CYC),
        .RAS_CYC     (RAS_CYC),
        .PRE_CYC     (PRE_CYC),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_gnt   (ref_gnt),
        .pend_nz   (pend_nz),
        .pend_dec  (pend_dec),
        .ref_req   (ref_req),
        .init_done (done),
        .ras_n     (ras_n),
        .cas_n     (cas_n)
    );

    assign init_done = done;
    assign we_n      = 1'b1;
    assign oe_n      = 1'b1;

endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;

    localparam int PAUSE = 50000;
    localparam int INTV  = 3906;
    localparam int NINIT = 8;
    localparam int MAXP  = 4;
    localparam int RASL  = 15;
    localparam int PREH  = 13;
    localparam int LEAD  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, init_done, ras_n, cas_n, we_n, oe_n;

    int n_chk = 0, n_fail = 0;
    int ras_falls = 0, cas_falls = 0;
    int cyc = 0, low_run = 0, high_run = 0, cas_run = 0;
    bit cas_ok = 1'b1, prev_ras = 1'b1, prev_cas = 1'b1, prev_init = 1'b0;

    always #2 clk = ~clk;

    dram_refresh_seq u_dut (
        .clk (clk), .rst_n (rst_n), .ref_gnt (ref_gnt), .ref_req (ref_req),
        .init_done (init_done), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .oe_n (oe_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_burst(input int n);
        return (n > MAXP) ? MAXP : n;
    endfunction

    // Strobe monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                ras_falls++;
                chk(!cas_n && cas_run >= LEAD, "R4 cas lead", cas_run, LEAD);
                chk(high_run >= PREH, "R5 precharge", high_run, PREH);
                chk(we_n && oe_n, "R9 we/oe high", {we_n, oe_n}, 3);
                cas_ok = 1'b1;
            end
            if (!prev_ras && ras_n) begin
                chk(low_run == RASL, "R5 ras low width", low_run, RASL);
                chk(cas_ok, "R4 cas hold", cas_ok, 1);
            end
            if (!ras_n && cas_n) cas_ok = 1'b0;
            if (prev_cas && !cas_n) cas_falls++;
            low_run  = ras_n ? 0 : low_run + 1;
            high_run = ras_n ? high_run + 1 : 0;
            cas_run  = cas_n ? 0 : cas_run + 1;
            cyc      = (init_done && !prev_init) ? 0 : cyc + 1;
            prev_ras = ras_n; prev_cas = cas_n; prev_init = init_done;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic burst(input int exp_n, input string tag);
        int f0, c0;
        chk(ref_req, {tag, " req before grant"}, ref_req, 1);
        f0 = ras_falls; c0 = cas_falls;
        ref_gnt = 1'b1;
        step();
        chk(!cas_n, "R7 cas falls after grant", cas_n, 0);
        while (ref_req) step();
        ref_gnt = 1'b0;
        chk(ras_falls - f0 == exp_n, {tag, " burst size"}, ras_falls - f0, exp_n);
        chk(cas_falls - c0 == 1, "R8 single cas fall", cas_falls - c0, 1);
        chk(cas_n && ras_n, "R8 strobes idle after burst", {cas_n, ras_n}, 3);
    endtask

    task automatic held_round(input int h, input int off);
        int target, mark;
        mark = ras_falls;
        target = (cyc / INTV + h) * INTV + off;
        while (cyc < target) step();
        chk(ras_falls == mark, "R7 no strobe before grant", ras_falls, mark);
        burst(exp_burst(h), (h > MAXP) ? "R8" : "R6");
    endtask

    initial begin
        int n;
        void'($urandom(32'd1234));
        repeat (3) step();
        chk(ras_n && cas_n && we_n && oe_n, "R1 strobes in reset",
            {ras_n, cas_n, we_n, oe_n}, 15);
        chk(!ref_req && !init_done, "R1 flags in reset", {ref_req, init_done}, 0);
        rst_n = 1'b1;
        n = 0;
        while (cas_n) begin step(); n++; end
        chk(n == PAUSE, "R2 pause length", n, PAUSE);
        chk(ras_falls == 0, "R2 no ras in pause", ras_falls, 0);
        while (!init_done) begin
            step();
            if (ref_req) chk(0, "R3 req during init", 1, 0);
        end
        chk(ras_falls == NINIT, "R3 init count", ras_falls, NINIT);
        chk(cas_falls == 1, "R3 init chained", cas_falls, 1);
        chk(ras_n && cas_n, "R3 idle at init_done", {ras_n, cas_n}, 3);
        while (!ref_req) step();
        chk(cyc == INTV, "R6 first request", cyc, INTV);
        n = ras_falls;
        repeat ($urandom_range(1, 20)) step();
        chk(ras_falls == n, "R7 hold until grant", ras_falls, n);
        burst(1, "R6");
        held_round(6, 10);
        for (int i = 0; i < 4; i++)
            held_round($urandom_range(1, 5), $urandom_range(1, 400));
        chk(init_done, "R3 init_done sticky", init_done, 1);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule